// File: doc/BRIEF.md
# Microcoded Accumulator Processor

This block is a small accumulator processor whose every action comes from a fixed 128-word by 20-bit microprogram store. The store is computed inside the block, so nothing loads it. A control address register (the micro-PC) steps through that store. Each microinstruction carries three 3-bit operation fields, a 2-bit condition select, a 2-bit sequencing mode and a 7-bit target address. Each operation field is decoded one-of-eight and enables register transfers. The datapath holds an 11-bit program counter and address register, a 16-bit data register and accumulator, and a word memory of 2^MEM_AW entries.

A machine word holds the indirect flag in bit 15, the opcode in bits 14..11 and the address in bits 10..0. Four opcodes have microroutines. Opcode *k* is mapped to micro-address 4*k*. Instruction fetch lives at micro-address 64, and the indirect-address subroutine lives at 67.

A `halt` input freezes the processor between any two microinstructions. While halted, a debug port can write memory, and memory can always be read on `dbg_rdata`. This lets a host load a program and then single-step instructions. It does so by releasing `halt` until the micro-PC output returns to 64.

Top module: `ucode_acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, PC and AC become 0 and the micro-PC becomes 64.
- R2: Each instruction is fetched from M[PC] in three microcycles: PC to AR; read and PC+1; then AR from data bits 10..0 and dispatch. The micro-PC then lands on 4 × opcode (bits 14..11), and it shows 64 again when the instruction completes.
- R3: Opcode 0000 sets AC to (AC + M[EA]) mod 2^16 and takes 6 cycles when direct.
- R4: Opcode 0001 loads PC with EA when AC bit 15 is 1 (6 cycles direct). Otherwise PC only advances by one (5 cycles), and the indirect flag then adds no cycles.
- R5: Opcode 0010 writes AC into M[EA] and leaves AC unchanged, in 6 cycles when direct.
- R6: Opcode 0011 swaps AC and M[EA]. AC and the data register are exchanged on one clock edge using the values from before it. The instruction takes 7 cycles when direct.
- R7: With bit 15 set, EA is bits 10..0 of M[address field]. This costs two extra cycles on opcodes 0000, 0010 and 0011, and on 0001 when the branch is taken.
- R8: Opcodes 0100 to 1111 change nothing but PC, which advances by one. They take 4 cycles whatever the indirect bit holds.
- R9: While `halt` is high, PC, AC and the micro-PC hold their values, a debug write stores `dbg_wdata` at `dbg_addr`, and `dbg_rdata` always shows M[`dbg_addr`].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes microinstruction execution |
| dbg_we | input | 1 | Debug memory write strobe, honoured only while halted |
| dbg_addr | input | MEM_AW | Debug memory address |
| dbg_wdata | input | 16 | Debug write data |
| dbg_rdata | output | 16 | Memory word at `dbg_addr` |
| pc_out | output | 11 | Program counter |
| ac_out | output | 16 | Accumulator |
| upc_out | output | 7 | Micro-PC (control address register) |

## Verification
Two transfers must share one edge and read only the old register values. The first is the exchange step, where AC takes the data register while the data register takes AC. The second is the fetch step, where a memory read into the data register coincides with the PC increment. Every exchange in the sweep loads AC from a zero accumulator and writes 0 back to memory. The bench then reads the swapped memory word through the debug port. A wrong sampling order would leave either AC or the memory word equal to the new value. The PC after every fetch is also compared against the instruction count. A read that saw the incremented PC would execute the wrong word and break the later results and cycle counts.

// File: rtl/ucode_acc_cpu.sv
module ucode_acc_cpu #(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              dbg_we,
  input  logic [MEM_AW-1:0] dbg_addr,
  input  logic [15:0]       dbg_wdata,
  output logic [15:0]       dbg_rdata,
  output logic [10:0]       pc_out,
  output logic [15:0]       ac_out,
  output logic [6:0]        upc_out
);
  localparam logic [1:0] C_ALW = 2'd0, C_IND = 2'd1, C_NEG = 2'd2, C_ZER = 2'd3;
  localparam logic [1:0] S_JMP = 2'd0, S_CALL = 2'd1, S_RET = 2'd2, S_MAP = 2'd3;
  localparam logic [2:0] A_ADD = 3'd1, A_DRTAC = 3'd4, A_DRTAR = 3'd5, A_PCTAR = 3'd6, A_WRITE = 3'd7;
  localparam logic [2:0] B_READ = 3'd4, B_ACTDR = 3'd5;
  localparam logic [2:0] X_INCPC = 3'd5, X_ARTPC = 3'd6;
  localparam logic [6:0] FETCH = 7'd64, INDIR = 7'd67;

  function automatic logic [19:0] mi(input logic [2:0] a, input logic [2:0] b, input logic [2:0] x,
                                     input logic [1:0] c, input logic [1:0] s, input logic [6:0] t);
    return {a, b, x, c, s, t};
  endfunction

  function automatic logic [19:0] urom(input logic [6:0] u);
    case (u)
      7'd0:   urom = mi(3'd0,    3'd0,    3'd0,    C_IND, S_CALL, INDIR);
      7'd1:   urom = mi(3'd0,    B_READ,  3'd0,    C_ALW, S_JMP,  7'd2);
      7'd2:   urom = mi(A_ADD,   3'd0,    3'd0,    C_ALW, S_JMP,  FETCH);
      7'd4:   urom = mi(3'd0,    3'd0,    3'd0,    C_NEG, S_JMP,  7'd6);
      7'd5:   urom = mi(3'd0,    3'd0,    3'd0,    C_ALW, S_JMP,  FETCH);
      7'd6:   urom = mi(3'd0,    3'd0,    3'd0,    C_IND, S_CALL, INDIR);
      7'd7:   urom = mi(3'd0,    3'd0,    X_ARTPC, C_ALW, S_JMP,  FETCH);
      7'd8:   urom = mi(3'd0,    3'd0,    3'd0,    C_IND, S_CALL, INDIR);
      7'd9:   urom = mi(3'd0,    B_ACTDR, 3'd0,    C_ALW, S_JMP,  7'd10);
      7'd10:  urom = mi(A_WRITE, 3'd0,    3'd0,    C_ALW, S_JMP,  FETCH);
      7'd12:  urom = mi(3'd0,    3'd0,    3'd0,    C_IND, S_CALL, INDIR);
      7'd13:  urom = mi(3'd0,    B_READ,  3'd0,    C_ALW, S_JMP,  7'd14);
      7'd14:  urom = mi(A_DRTAC, B_ACTDR, 3'd0,    C_ALW, S_JMP,  7'd15);
      7'd15:  urom = mi(A_WRITE, 3'd0,    3'd0,    C_ALW, S_JMP,  FETCH);
      7'd64:  urom = mi(A_PCTAR, 3'd0,    3'd0,    C_ALW, S_JMP,  7'd65);
      7'd65:  urom = mi(3'd0,    B_READ,  X_INCPC, C_ALW, S_JMP,  7'd66);
      7'd66:  urom = mi(A_DRTAR, 3'd0,    3'd0,    C_ALW, S_MAP,  7'd0);
      7'd67:  urom = mi(3'd0,    B_READ,  3'd0,    C_ALW, S_JMP,  7'd68);
      7'd68:  urom = mi(A_DRTAR, 3'd0,    3'd0,    C_ALW, S_RET,  7'd0);
      default: urom = mi(3'd0,   3'd0,    3'd0,    C_ALW, S_JMP,  FETCH);
    endcase
  endfunction

  logic [15:0] mem [0:(1<<MEM_AW)-1];
  logic [6:0]  car, sbr, car_nxt;
  logic [10:0] pc, ar;
  logic [15:0] dr, ac;
  logic [19:0] uw;
  logic [2:0]  f1, f2, f3;
  logic [1:0]  cd, br;
  logic [6:0]  ad;
  logic        cond;
  logic [15:0] rd;

  assign uw = urom(car);
  assign {f1, f2, f3, cd, br, ad} = uw;
  assign rd = mem[ar[MEM_AW-1:0]];
  assign dbg_rdata = mem[dbg_addr];
  assign pc_out = pc;
  assign ac_out = ac;
  assign upc_out = car;

  always_comb begin
    case (cd)
      C_ALW:   cond = 1'b1;
      C_IND:   cond = dr[15];
      C_NEG:   cond = ac[15];
      default: cond = (ac == 16'd0);
    endcase
    case (br)
      S_RET:   car_nxt = sbr;
      S_MAP:   car_nxt = {1'b0, dr[14:11], 2'b00};
      default: car_nxt = cond ? ad : car + 7'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!halt && f1 == A_WRITE) mem[ar[MEM_AW-1:0]] <= dr;
    else if (halt && dbg_we)    mem[dbg_addr] <= dbg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= FETCH;
      sbr <= '0;
      pc  <= '0;
      ar  <= '0;
      dr  <= '0;
      ac  <= '0;
    end else if (!halt) begin
      car <= car_nxt;
      if (br == S_CALL && cond) sbr <= car + 7'd1;
      case (f1)
        A_ADD:   ac <= ac + dr;
        A_DRTAC: ac <= dr;
        A_DRTAR: ar <= dr[10:0];
        A_PCTAR: ar <= pc;
        default: ;
      endcase
      case (f2)
        B_READ:  dr <= rd;
        B_ACTDR: dr <= ac;
        default: ;
      endcase
      case (f3)
        X_INCPC: pc <= pc + 11'd1;
        X_ARTPC: pc <= ar;
        default: ;
      endcase
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) $past(rst) |-> (car == FETCH && pc == 11'd0 && ac == 16'd0));
  a_r2_map_target: assert property (@(posedge clk) disable iff (rst)
    (!halt && car == 7'd66) |=> (car[6] == 1'b0 && car[1:0] == 2'b00));
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!halt && car == 7'd65) |=> pc == $past(pc) + 11'd1);
  a_r6_swap: assert property (@(posedge clk) disable iff (rst)
    (!halt && car == 7'd14) |=> (ac == $past(dr) && dr == $past(ac)));
  a_r7_return_low: assert property (@(posedge clk) disable iff (rst)
    (!halt && car == 7'd68) |=> car < FETCH);
  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(pc) && $stable(ac) && $stable(car)));
endmodule

// File: tb/test_ucode_acc_cpu.sv
module test_ucode_acc_cpu;
  localparam int MAW = 8;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, halt = 1'b1, dbg_we = 1'b0;
  logic [MAW-1:0] dbg_addr = '0;
  logic [15:0] dbg_wdata = '0, dbg_rdata, ac_out;
  logic [10:0] pc_out;
  logic [6:0] upc_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  ucode_acc_cpu #(.MEM_AW(MAW)) i_ucode_acc_cpu (
    .clk(clk), .rst(rst), .halt(halt), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .pc_out(pc_out),
    .ac_out(ac_out), .upc_out(upc_out));

  function automatic logic [15:0] enc(input logic i, input int op, input int a);
    return {i, 4'(op), 11'(a)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mw(input int a, input logic [15:0] d);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = MAW'(a); dbg_wdata = d;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic mr(input int a, output logic [15:0] d);
    dbg_addr = MAW'(a);
    #1 d = dbg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; halt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(output int cyc);
    @(negedge clk);
    halt = 1'b0;
    cyc = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end while (upc_out != 7'd64 && cyc < 100);
    halt = 1'b1;
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    if (!done) $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] d, s;
    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h1234, 16'h00FF, 16'hC000};
    do_reset();
    chk("R1 pc", 32'(pc_out), 0);
    chk("R1 ac", 32'(ac_out), 0);
    chk("R1 upc", 32'(upc_out), 64);

    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        do_reset();
        mw(0, enc(0, 3, 'h80)); mw(1, enc(0, 0, 'h81));
        mw(2, enc(0, 2, 'h82)); mw(3, enc(0, 1, 'h40));
        mw('h80, vals[ia]); mw('h81, vals[ib]); mw('h82, 16'hDEAD);
        s = vals[ia] + vals[ib];
        step(cyc);
        chk("R6 exch cycles", cyc, 7);
        chk("R6 exch ac", 32'(ac_out), 32'(vals[ia]));
        mr('h80, d); chk("R6 exch mem", 32'(d), 0);
        chk("R2 pc after 1", 32'(pc_out), 1);
        step(cyc);
        chk("R3 add cycles", cyc, 6);
        chk("R3 add ac", 32'(ac_out), 32'(s));
        chk("R2 pc after 2", 32'(pc_out), 2);
        step(cyc);
        chk("R5 store cycles", cyc, 6);
        mr('h82, d); chk("R5 store mem", 32'(d), 32'(s));
        chk("R5 store ac", 32'(ac_out), 32'(s));
        step(cyc);
        chk("R4 branch cycles", cyc, s[15] ? 6 : 5);
        chk("R4 branch pc", 32'(pc_out), s[15] ? 'h40 : 4);
        chk("R2 upc boundary", 32'(upc_out), 64);
      end
    end

    for (int t = 0; t < 2; t++) begin
      logic [15:0] v;
      v = (t == 0) ? 16'h8001 : 16'h0007;
      do_reset();
      mw('h90, 16'h00A1); mw('hA1, v);
      mw('h91, 16'h00A2); mw('hA2, 16'h0000);
      mw('h93, 16'h00A3); mw('hA3, 16'h0003);
      mw('h92, 16'h0055);
      mw(0, enc(1, 3, 'h90)); mw(1, enc(1, 2, 'h91));
      mw(2, enc(1, 0, 'h93)); mw(3, enc(1, 1, 'h92));
      step(cyc);
      chk("R7 ind exch cycles", cyc, 9);
      chk("R7 ind exch ac", 32'(ac_out), 32'(v));
      mr('hA1, d); chk("R7 ind exch mem", 32'(d), 0);
      step(cyc);
      chk("R7 ind store cycles", cyc, 8);
      mr('hA2, d); chk("R7 ind store mem", 32'(d), 32'(v));
      step(cyc);
      s = v + 16'd3;
      chk("R7 ind add cycles", cyc, 8);
      chk("R7 ind add ac", 32'(ac_out), 32'(s));
      step(cyc);
      chk("R7 ind branch cycles", cyc, s[15] ? 8 : 5);
      chk("R7 ind branch pc", 32'(pc_out), s[15] ? 'h55 : 4);
    end

    do_reset();
    mw('h33, 16'h5A5A);
    for (int k = 4; k < 16; k++) mw(k - 4, enc(k[0], k, 'h33));
    for (int k = 4; k < 16; k++) begin
      step(cyc);
      chk("R8 undef cycles", cyc, 4);
      chk("R8 undef pc", 32'(pc_out), k - 3);
      chk("R8 undef ac", 32'(ac_out), 0);
      mr('h33, d); chk("R8 undef mem", 32'(d), 16'h5A5A);
    end

    begin
      logic [10:0] p0; logic [15:0] a0; logic [6:0] u0;
      do_reset();
      mw('h80, 16'h4321); mw(0, enc(0, 3, 'h80)); mw(1, enc(0, 0, 'h80));
      @(negedge clk);
      halt = 1'b0;
      repeat (9) @(negedge clk);
      halt = 1'b1;
      @(negedge clk);
      p0 = pc_out; a0 = ac_out; u0 = upc_out;
      repeat (5) @(negedge clk);
      chk("R9 halt pc", 32'(pc_out), 32'(p0));
      chk("R9 halt ac", 32'(ac_out), 32'(a0));
      chk("R9 halt upc", 32'(upc_out), 32'(u0));
      mw('hC7, 16'hBEEF);
      mr('hC7, d); chk("R9 debug write", 32'(d), 16'hBEEF);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule